// File: doc/BRIEF.md
# Threshold Transfer FIFO with Request Pacing

This block holds the bytes of the data-transfer (execution) phase of a disk controller command. It sits between the disk data path and the host bus. For a disk read, the disk side pushes bytes and the host pops them. For a disk write, the host writes bytes and the disk side pops them. Command and result bytes never enter it. When the execution phase is inactive, the storage behaves as if it were switched off.

The block tells the host when to move data. It uses a programmable 4-bit threshold to decide when a batch is ready. It then raises either a DMA request or an interrupt request, chosen by the transfer mode. There are two pacing styles:
- In burst style, the request is held until the batch is finished.
- In non-burst style, the request drops for a fixed gap after every host transfer, so other requesters can get the bus.

A DMA terminal count ends the request. It is accepted only while the DMA acknowledge is active, and its polarity is selectable.

The configuration is held in the block. A hardware reset returns it to the defaults. A software reset also returns it to the defaults, unless the configuration was locked.

Top module: `xfer_fifo_pacer`

## Requirements
- R1: After a hardware reset, both requests are low, the storage is empty, and both error flags are clear. The configuration is the default: storage off, threshold 0, non-burst style, no direction disabled, lock clear.
- R2: For a disk read (`dir_read`=1) with the storage on, a request is raised on the cycle after the held byte count first reaches threshold+1.
- R3: For a disk write (`dir_read`=0) with the storage on, a request is raised on the cycle after the free space first reaches threshold+1.
- R4: In three cases the block acts as a single-byte buffer with an effective threshold of 0: the storage is off, the current direction is disabled (`cfg_rd_off` for reads, `cfg_wr_off` for writes), or the execution phase is inactive. Outside the execution phase, no request is raised.
- R5: In burst style (`cfg_burst`=1), a raised request stays high across host transfers. For a read it stays high until the storage is empty. For a write it stays high until the storage is full.
- R6: In non-burst style, each accepted host transfer drops the request for exactly GAP_CYC cycles. After the gap, the request returns if the batch is not finished.
- R7: Bytes leave in the order they were accepted, with their values unchanged. The depth is 16 entries.
- R8: Two events set sticky error flags. A disk-side push into a full store sets `overrun`, and the byte is discarded. A disk-side pop from an empty store sets `underrun`. `cmd_start` clears both flags and empties the store.
- R9: A terminal count is accepted only while `dack_n` is low. It is active high when `tc_act_low`=0 and active low when `tc_act_low`=1. Once accepted, it sets `tc_done` and holds both requests low until `cmd_start`.
- R10: `soft_rst` empties the store. When the lock bit is set, `soft_rst` keeps the configuration. When the lock bit is clear, `soft_rst` restores the default configuration.
- R11: When `dma_mode`=1 the request appears on `drq` only. When `dma_mode`=0 it appears on `irq` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset pulse |
| cmd_start | input | 1 | Start of a new command: clears flags, terminal count and storage |
| phase_exec | input | 1 | Execution phase active |
| dir_read | input | 1 | 1 = disk read (disk to host), 0 = disk write |
| dma_mode | input | 1 | 1 = DMA request, 0 = interrupt request |
| cfg_load | input | 1 | Load the configuration fields below |
| cfg_fifo_en | input | 1 | Storage on |
| cfg_thresh | input | 4 | Threshold |
| cfg_burst | input | 1 | Burst pacing |
| cfg_rd_off | input | 1 | Storage off for disk reads |
| cfg_wr_off | input | 1 | Storage off for disk writes |
| cfg_lock | input | 1 | Keep configuration across a software reset |
| dsk_push | input | 1 | Disk side pushes a byte (reads) |
| dsk_wdata | input | 8 | Disk side byte in |
| dsk_pop | input | 1 | Disk side pops a byte (writes) |
| dsk_rdata | output | 8 | Disk side byte out (head of storage) |
| dsk_full | output | 1 | Storage at its effective capacity |
| dsk_empty | output | 1 | Storage empty |
| host_rd | input | 1 | Host reads a byte (reads) |
| host_rdata | output | 8 | Host byte out (head of storage) |
| host_wr | input | 1 | Host writes a byte (writes) |
| host_wdata | input | 8 | Host byte in |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc_in | input | 1 | Terminal count |
| tc_act_low | input | 1 | Terminal count polarity select |
| drq | output | 1 | DMA service request |
| irq | output | 1 | Interrupt service request |
| tc_done | output | 1 | Terminal count accepted |
| overrun | output | 1 | Sticky overrun flag |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench looks at several corner cases of request timing:
- The exact count at which the request rises, in each direction. A threshold comparison that is off by one would raise the request a byte early or a byte late.
- The length of the non-burst gap. A gap counter with a miscounted load would bring the request back too early or too late.
- The burst hold. A request that is lost between bytes would show up as a drop across host transfers.

Terminal count is sent both without and with the acknowledge, and in both polarities. A design that ignores the acknowledge gate or the polarity select would end a transfer early, or would never end it. Other cases check that the default single-byte behaviour appears:
- after reset,
- when a direction is disabled,
- after an unlocked software reset but not after a locked one.

A pushed byte that is lost would also show up in the full flag or in the overrun flag.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
  localparam int XFP_TW = 4;

  typedef struct packed {
    logic              en;
    logic [XFP_TW-1:0] thr;
    logic              burst;
    logic              rd_off;
    logic              wr_off;
    logic              lock;
  } xfp_cfg_t;

  function automatic xfp_cfg_t xfp_cfg_default();
    xfp_cfg_t c;
    c.en     = 1'b0;
    c.thr    = '0;
    c.burst  = 1'b0;
    c.rd_off = 1'b0;
    c.wr_off = 1'b0;
    c.lock   = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/xfp_cfg_regs.sv
module xfp_cfg_regs
  import xfp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     cfg_load,
  input  xfp_cfg_t cfg_in,
  output xfp_cfg_t cfg_q
);
  xfp_cfg_t cfg_d;
  logic     cfg_ce;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_ce = 1'b0;
    if (soft_rst) begin
      if (!cfg_q.lock) begin
        cfg_d      = xfp_cfg_default();
        cfg_d.lock = cfg_q.lock;
        cfg_ce     = 1'b1;
      end
    end else if (cfg_load) begin
      cfg_d  = cfg_in;
      cfg_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= xfp_cfg_default();
    else if (cfg_ce) cfg_q <= cfg_d;
  end

  // R10: a locked configuration survives a software reset
  p_lock_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && cfg_q.lock) |=> $stable(cfg_q));
endmodule

// File: rtl/xfp_store.sv
module xfp_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] count_d,
  output logic          full,
  output logic          empty,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          wr_drop,
  output logic          rd_drop
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;

  assign full    = (count_q >= cap);
  assign empty   = (count_q == '0);
  assign wr_ok   = wr_en && !full && !flush;
  assign rd_ok   = rd_en && !empty && !flush;
  assign wr_drop = wr_en && full && !flush;
  assign rd_drop = rd_en && empty && !flush;
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_d    = wp_q;
    rp_d    = rp_q;
    count_d = count_q;
    if (flush) begin
      wp_d    = '0;
      rp_d    = '0;
      count_d = '0;
    end else begin
      if (wr_ok) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      count_d = count_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  // R7: occupancy never exceeds the storage depth
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R8: a refused push leaves the occupancy unchanged
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> $stable(count_q));
endmodule

// File: rtl/xfp_pacer.sv
module xfp_pacer #(
  parameter int CW      = 5,
  parameter int TW      = 4,
  parameter int GAP_CYC = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          exec,
  input  logic          dir_read,
  input  logic          burst,
  input  logic [TW-1:0] thr_eff,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] count_d,
  input  logic          host_xfer,
  input  logic          dack_n,
  input  logic          tc_in,
  input  logic          tc_act_low,
  input  logic          ovr_ev,
  input  logic          udr_ev,
  output logic          req,
  output logic          tc_seen_q,
  output logic          ovr_q,
  output logic          udr_q
);
  localparam int GW = (GAP_CYC < 1) ? 1 : $clog2(GAP_CYC + 1);

  logic          armed_q, armed_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          tc_seen_d, ovr_d, udr_d;
  logic [CW:0]   level, need;
  logic          trigger, done, tc_hit;

  assign tc_hit  = !dack_n && (tc_act_low ? !tc_in : tc_in);
  assign level   = dir_read ? (CW+1)'(count_d) : (CW+1)'(cap - count_d);
  assign need    = (CW+1)'(thr_eff) + (CW+1)'(1);
  assign trigger = (level >= need);
  assign done    = dir_read ? (count_d == '0) : (count_d == cap);

  always_comb begin
    if (clr || !exec || tc_hit) armed_d = 1'b0;
    else if (armed_q)           armed_d = !done;
    else                        armed_d = trigger;

    if (clr)                       gap_d = '0;
    else if (host_xfer && !burst)  gap_d = GW'(GAP_CYC);
    else if (gap_q != '0)          gap_d = gap_q - 1'b1;
    else                           gap_d = gap_q;

    tc_seen_d = clr ? 1'b0 : (tc_seen_q || tc_hit);
    ovr_d     = clr ? 1'b0 : (ovr_q || ovr_ev);
    udr_d     = clr ? 1'b0 : (udr_q || udr_ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      gap_q     <= '0;
      tc_seen_q <= 1'b0;
      ovr_q     <= 1'b0;
      udr_q     <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      gap_q     <= gap_d;
      tc_seen_q <= tc_seen_d;
      ovr_q     <= ovr_d;
      udr_q     <= udr_d;
    end
  end

  assign req = armed_q && (gap_q == '0) && !tc_seen_q && exec;

  // R6: a host transfer in non-burst style opens a gap at once
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_xfer && !burst && !clr && GAP_CYC > 0) |=> !req);
  // R9: terminal count is not taken without acknowledge
  p_tc_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_n && !tc_seen_q) |=> !tc_seen_q);
  // R8: command start clears the sticky error flags
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ovr_q && !udr_q));
endmodule

// File: rtl/xfer_fifo_pacer.sv
module xfer_fifo_pacer
  import xfp_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int GAP_CYC = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cmd_start,
  input  logic              phase_exec,
  input  logic              dir_read,
  input  logic              dma_mode,
  input  logic              cfg_load,
  input  logic              cfg_fifo_en,
  input  logic [XFP_TW-1:0] cfg_thresh,
  input  logic              cfg_burst,
  input  logic              cfg_rd_off,
  input  logic              cfg_wr_off,
  input  logic              cfg_lock,
  input  logic              dsk_push,
  input  logic [DW-1:0]     dsk_wdata,
  input  logic              dsk_pop,
  output logic [DW-1:0]     dsk_rdata,
  output logic              dsk_full,
  output logic              dsk_empty,
  input  logic              host_rd,
  output logic [DW-1:0]     host_rdata,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              dack_n,
  input  logic              tc_in,
  input  logic              tc_act_low,
  output logic              drq,
  output logic              irq,
  output logic              tc_done,
  output logic              overrun,
  output logic              underrun
);
  localparam int CW = $clog2(DEPTH + 1);

  xfp_cfg_t          cfg_in, cfg_q;
  logic              fifo_on, flush;
  logic [CW-1:0]     cap, count_q, count_d;
  logic [XFP_TW-1:0] thr_eff;
  logic              st_wr, st_rd, wr_ok, rd_ok, wr_drop, rd_drop;
  logic [DW-1:0]     st_wdata, st_rdata;
  logic              host_xfer, req;

  always_comb begin
    cfg_in.en     = cfg_fifo_en;
    cfg_in.thr    = cfg_thresh;
    cfg_in.burst  = cfg_burst;
    cfg_in.rd_off = cfg_rd_off;
    cfg_in.wr_off = cfg_wr_off;
    cfg_in.lock   = cfg_lock;
  end

  xfp_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_load(cfg_load),
    .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  assign flush   = cmd_start || soft_rst;
  assign fifo_on = cfg_q.en && phase_exec && !(dir_read ? cfg_q.rd_off : cfg_q.wr_off);
  assign cap     = fifo_on ? CW'(DEPTH) : CW'(1);
  assign thr_eff = fifo_on ? cfg_q.thr : '0;

  assign st_wr    = dir_read ? dsk_push  : host_wr;
  assign st_wdata = dir_read ? dsk_wdata : host_wdata;
  assign st_rd    = dir_read ? host_rd   : dsk_pop;

  xfp_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
    .wr_en(st_wr), .wr_data(st_wdata), .rd_en(st_rd), .rd_data(st_rdata),
    .count_q(count_q), .count_d(count_d), .full(dsk_full), .empty(dsk_empty),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_drop(wr_drop), .rd_drop(rd_drop)
  );

  assign host_xfer = dir_read ? rd_ok : wr_ok;

  xfp_pacer #(.CW(CW), .TW(XFP_TW), .GAP_CYC(GAP_CYC)) u_pacer (
    .clk(clk), .rst_n(rst_n), .clr(flush), .exec(phase_exec),
    .dir_read(dir_read), .burst(cfg_q.burst), .thr_eff(thr_eff), .cap(cap),
    .count_d(count_d), .host_xfer(host_xfer), .dack_n(dack_n), .tc_in(tc_in),
    .tc_act_low(tc_act_low), .ovr_ev(dir_read && wr_drop),
    .udr_ev(!dir_read && rd_drop), .req(req), .tc_seen_q(tc_done),
    .ovr_q(overrun), .udr_q(underrun)
  );

  assign dsk_rdata  = st_rdata;
  assign host_rdata = st_rdata;
  assign drq        = req && dma_mode;
  assign irq        = req && !dma_mode;

  // R4: no request outside the execution phase
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_exec |-> !(drq || irq));
endmodule

// File: tb/tb_xfer_fifo_pacer.sv
module tb_xfer_fifo_pacer;
  localparam int GAP = 9;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, soft_rst, cmd_start, phase_exec, dir_read, dma_mode;
  logic cfg_load, cfg_fifo_en, cfg_burst, cfg_rd_off, cfg_wr_off, cfg_lock;
  logic [3:0] cfg_thresh;
  logic dsk_push, dsk_pop, dsk_full, dsk_empty, host_rd, host_wr;
  logic [7:0] dsk_wdata, dsk_rdata, host_rdata, host_wdata;
  logic dack_n, tc_in, tc_act_low, drq, irq, tc_done, overrun, underrun;

  xfer_fifo_pacer dut (.*);

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input string rq, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // scoreboard monitor: compares each outgoing byte with the expected queue
  always @(negedge clk) begin
    #1;
    if (((host_rd && dir_read) || (dsk_pop && !dir_read)) && exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk("R7 data", dir_read ? host_rdata : dsk_rdata, e);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic push_dsk(input logic [7:0] d, input bit keep);
    dsk_push = 1; dsk_wdata = d; if (keep) exp_q.push_back(d);
    @(negedge clk); dsk_push = 0;
  endtask
  task automatic wr_host(input logic [7:0] d);
    host_wr = 1; host_wdata = d; exp_q.push_back(d);
    @(negedge clk); host_wr = 0;
  endtask
  task automatic rd_host();
    host_rd = 1; @(negedge clk); host_rd = 0;
  endtask
  task automatic pop_dsk();
    dsk_pop = 1; @(negedge clk); dsk_pop = 0;
  endtask
  task automatic new_cmd();
    cmd_start = 1; exp_q.delete(); @(negedge clk); cmd_start = 0;
  endtask
  task automatic sreset();
    soft_rst = 1; exp_q.delete(); @(negedge clk); soft_rst = 0;
  endtask
  task automatic set_cfg(input bit en, input int thr, input bit b,
                         input bit ro, input bit wo, input bit lk);
    cfg_load = 1; cfg_fifo_en = en; cfg_thresh = 4'(thr); cfg_burst = b;
    cfg_rd_off = ro; cfg_wr_off = wo; cfg_lock = lk;
    @(negedge clk); cfg_load = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_rst = 0; cmd_start = 0; phase_exec = 0; dir_read = 1;
    dma_mode = 1; cfg_load = 0; cfg_fifo_en = 0; cfg_thresh = 0; cfg_burst = 0;
    cfg_rd_off = 0; cfg_wr_off = 0; cfg_lock = 0; dsk_push = 0; dsk_pop = 0;
    host_rd = 0; host_wr = 0; dsk_wdata = 0; host_wdata = 0;
    dack_n = 1; tc_in = 0; tc_act_low = 0;
    cyc(4); rst_n = 1; cyc(1);
    // R1: reset state
    chk("R1 drq", drq, 0); chk("R1 irq", irq, 0);
    chk("R1 empty", dsk_empty, 1); chk("R1 ovr", overrun, 0); chk("R1 udr", underrun, 0);
    // R4: outside exec phase no request even with data
    push_dsk(8'h11, 0);
    chk("R4 idle no req", drq, 0);
    new_cmd();
    phase_exec = 1; cyc(1);
    // R1/R4: default config acts as one-byte buffer, threshold 0
    push_dsk(8'hA5, 1);
    chk("R1 default full", dsk_full, 1); chk("R4 req thr0", drq, 1);
    push_dsk(8'h3C, 0);
    chk("R8 overrun", overrun, 1);
    rd_host();
    chk("R4 drained", drq, 0);
    new_cmd();
    chk("R8 clear", overrun, 0);

    // R2 + R5: threshold 3, burst
    set_cfg(1, 3, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) push_dsk(8'(8'h20 + i), 1);
    chk("R2 below thr", drq, 0);
    push_dsk(8'h23, 1);
    chk("R2 at thr", drq, 1);
    for (int i = 0; i < 3; i++) begin rd_host(); chk("R5 burst hold", drq, 1); end
    rd_host();
    chk("R5 batch end", drq, 0);

    // R6: non-burst gap
    set_cfg(1, 1, 0, 0, 0, 0); new_cmd();
    push_dsk(8'h51, 1); push_dsk(8'h52, 1);
    chk("R6 req", drq, 1);
    rd_host();
    for (int k = 0; k < GAP; k++) begin chk("R6 gap low", drq, 0); cyc(1); end
    chk("R6 gap end", drq, 1);
    rd_host();
    cyc(GAP + 1);
    chk("R6 done", drq, 0);

    // R11: interrupt routing
    dma_mode = 0; new_cmd();
    push_dsk(8'h61, 1); push_dsk(8'h62, 1);
    chk("R11 irq", irq, 1); chk("R11 no drq", drq, 0);
    rd_host(); rd_host();
    dma_mode = 1;

    // R3: write direction, threshold 3, burst
    dir_read = 0; set_cfg(1, 3, 1, 0, 0, 0); new_cmd(); cyc(1);
    chk("R3 empty room", drq, 1);
    for (int i = 0; i < 12; i++) wr_host(8'(8'h80 + i));
    chk("R5 write hold", drq, 1);
    for (int i = 12; i < 16; i++) wr_host(8'(8'h80 + i));
    chk("R5 write full", drq, 0); chk("R7 full16", dsk_full, 1);
    pop_dsk(); pop_dsk(); pop_dsk();
    chk("R3 room3", drq, 0);
    pop_dsk();
    chk("R3 room4", drq, 1);
    for (int i = 0; i < 12; i++) pop_dsk();
    chk("R7 empty", dsk_empty, 1);
    pop_dsk();
    chk("R8 underrun", underrun, 1);

    // R4: write direction disabled -> single byte
    set_cfg(1, 3, 1, 0, 1, 0); new_cmd(); cyc(1);
    chk("R4 wr_off req", drq, 1);
    wr_host(8'h99);
    chk("R4 wr_off full", dsk_full, 1); chk("R4 wr_off drop", drq, 0);

    // R9: terminal count
    dir_read = 1; set_cfg(1, 0, 1, 0, 0, 0); new_cmd();
    push_dsk(8'h71, 0); push_dsk(8'h72, 0);
    chk("R9 pre", drq, 1);
    tc_in = 1; cyc(1); tc_in = 0; cyc(1);
    chk("R9 tc no dack", drq, 1);
    dack_n = 0; tc_in = 1; cyc(1); dack_n = 1; tc_in = 0; cyc(1);
    chk("R9 tc taken", drq, 0); chk("R9 tc_done", tc_done, 1);
    push_dsk(8'h73, 0);
    chk("R9 stays low", drq, 0);
    new_cmd();
    push_dsk(8'h74, 0);
    chk("R9 rearm", drq, 1);
    tc_act_low = 1; tc_in = 1; dack_n = 0; cyc(2);
    chk("R9 low pol idle", drq, 1);
    tc_in = 0; cyc(1); tc_in = 1; dack_n = 1; cyc(1);
    chk("R9 low pol taken", drq, 0);
    tc_act_low = 0; tc_in = 0;

    // R10: locked soft reset keeps threshold 3
    set_cfg(1, 3, 1, 0, 0, 1); new_cmd(); sreset();
    for (int i = 0; i < 3; i++) push_dsk(8'(i), 0);
    chk("R10 lock thr", drq, 0);
    push_dsk(8'h03, 0);
    chk("R10 lock trig", drq, 1);
    set_cfg(1, 3, 1, 0, 0, 0); sreset();
    push_dsk(8'h44, 0);
    chk("R10 unlock req", drq, 1); chk("R10 unlock full", dsk_full, 1);
    new_cmd();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule